// File: doc/BRIEF.md
# Second-Tick Status and Programmable Timer Output

This block sits beside a calendar counter in a real-time-clock subsystem and runs entirely from the 32768 Hz timebase. A free-running prescaler divides the timebase to mark each second boundary. From that boundary the block derives a host-visible busy window and a sticky missed-tick flag. A host polls this pair so that its register accesses stay clear of the calendar update, and so that it can tell when a multi-register read crossed a second boundary and must be repeated.

The block also drives two output pins. One is a fixed 4096 Hz square wave. The other is a timer pin set by a 4-bit select code. That code picks a square wave between 1 Hz and 2048 Hz, a single-cycle pulse on the calendar's minute or ten-minute carry, or a constant level. When the select code changes, the square-wave phase restarts from a known point, so the pin never shows a runt pulse.

Top module: `rtc_tick_status`

## Requirements
- R1: For select codes 0 to 11, `tmr_out` is a 50% duty square wave at 2^code Hz. Each level lasts 2^(14-code) timebase cycles.
- R2: For code 12, `tmr_out` is high for exactly one cycle, one cycle after a rising edge of `min_carry`. Code 13 behaves the same way on `ten_carry`. A carry held high for several cycles gives one pulse. The carry that is not selected has no effect on the pin.
- R3: Code 14 holds `tmr_out` high and code 15 holds it low.
- R4: `khz_out` is a free-running square wave with an 8-cycle period: 4 cycles high, then 4 cycles low.
- R5: Busy (`status[1]`) is high for 6 consecutive cycles around each second boundary: the 3 cycles before it and the 3 after it. Boundaries are 32768 cycles apart. The first busy cycle follows the 32762nd clock edge after reset is released.
- R6: The missed-tick flag (`status[0]`) is set on every clock edge at which busy is high. It is cleared on the first clock edge at which `stat_rd` is sampled low after being sampled high. Otherwise it holds its value.
- R7: If the trailing edge of `stat_rd` meets a busy cycle, the set wins and the flag reads 1.
- R8: `status` carries busy in bit 1 and the missed-tick flag in bit 0. Bits 3 and 2 read 0.
- R9: While reset is held, `tmr_out`, `khz_out` and all of `status` are 0.
- R10: After a change of select code, the old waveform continues for one more cycle. The pin then goes low, and a new square wave starts from phase zero: its first rise comes one half period later. No level on the pin lasts less than one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 4 | Timer output select code |
| min_carry | input | 1 | Minute carry from the calendar |
| ten_carry | input | 1 | Ten-minute carry from the calendar |
| stat_rd | input | 1 | Status read strobe, active high |
| tmr_out | output | 1 | Programmable timer pin |
| khz_out | output | 1 | Fixed 4096 Hz pin |
| status | output | 4 | Status nibble: busy, missed-tick flag |

## Verification
The bench places the trailing edge of a status read on the first busy cycle of a second boundary. A design that let the clear win would briefly read the flag as 0 and lose a tick. The bench changes the select code in the middle of a half period, both to a faster square wave and back to a slower one. A divider that kept its old phase would produce a rise too early, or a runt level. For the carry-pulse codes, the bench holds a carry high for several cycles and also pulses the carry that is not selected. A level-following output would stretch the pulse, and a wrong mux would show a pulse on the pin. The prescaler runs through two full seconds. This exposes any off-by-one in the busy window's placement or length, and any wrong reset phase.

// File: rtl/rtc_tick_pkg.sv
// Package: shared select-code type and the fixed code assignments of the
// timer output. Assumes a 4-bit select field with the constant and
// carry-pulse codes placed above the square-wave codes.
package rtc_tick_pkg;
    localparam int SEL_W = 4;
    typedef logic [SEL_W-1:0] sel_t;

    // Number of square-wave codes (0 .. NUM_SQ-1)
    localparam int NUM_SQ  = 12;
    localparam sel_t SEL_MIN = sel_t'(12);
    localparam sel_t SEL_TEN = sel_t'(13);
    localparam sel_t SEL_HI  = sel_t'(14);
    localparam sel_t SEL_LO  = sel_t'(15);
endpackage

// File: rtl/rtc_prescaler.sv
// Module: free-running timebase prescaler. It produces the busy window
// around each second boundary (the wrap of the counter) and the fixed
// 4096 Hz output. Assumes clk is the 32768 Hz timebase. The counter starts
// at BUSY_POST after reset, so the window does not open at reset release.
module rtc_prescaler #(
    parameter int DIV_W     = 15,
    parameter int KHZ_LOG2  = 3,
    parameter int BUSY_PRE  = 3,
    parameter int BUSY_POST = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy,
    output logic khz
);
    localparam longint SPAN = longint'(1) << DIV_W;
    localparam logic [DIV_W-1:0] WIN_OPEN  = DIV_W'(SPAN - BUSY_PRE);
    localparam logic [DIV_W-1:0] WIN_CLOSE = DIV_W'(BUSY_POST);
    localparam logic [DIV_W-1:0] CNT_INIT  = DIV_W'(BUSY_POST);
    localparam int KHZ_BIT = KHZ_LOG2 - 1;
    localparam int WIN     = BUSY_PRE + BUSY_POST;
    localparam int RUN_W   = $clog2(WIN + 2);

    logic [DIV_W-1:0] pre_cnt;

    // Advance the prescaler by one every timebase cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pre_cnt <= CNT_INIT;
        else        pre_cnt <= pre_cnt + 1'b1;
    end

    // Decode the window that brackets the wrap (second boundary)
    always_comb begin
        busy = (pre_cnt >= WIN_OPEN) || (pre_cnt < WIN_CLOSE);
    end

    // Register the divided-by-8 output for a clean pin
    always_ff @(posedge clk) begin
        if (!rst_n) khz <= 1'b0;
        else        khz <= pre_cnt[KHZ_BIT];
    end

    // Checker state: length of the current busy run
    logic [RUN_W-1:0] busy_run;
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    // R5: each busy run lasts exactly the window length
    a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == RUN_W'(WIN)));

    // R4: the 4 kHz pin never holds a level for only one cycle
    a_r4_khz_min_level: assert property (@(posedge clk) disable iff (!rst_n)
        (khz != $past(khz)) && $past(rst_n) |=> $stable(khz));
endmodule

// File: rtl/rtc_tout_sel.sv
// Module: programmable timer output. It has its own phase counter, which
// restarts whenever the registered select code differs from the incoming
// one, and a generate-built bank of square-wave taps. It also edge-detects
// the two calendar carries. Assumes the carries are synchronous to clk.
module rtc_tout_sel
    import rtc_tick_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  sel_t sel,
    input  logic min_carry,
    input  logic ten_carry,
    output logic tmr
);
    localparam int NCODE = 1 << SEL_W;

    sel_t             sel_q;
    logic [DIV_W-1:0] ph_cnt;
    logic             min_prev;
    logic             ten_prev;
    logic [NCODE-1:0] sq;
    logic             tmr_d;

    // Track the select code and restart the phase counter on any change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= SEL_LO;
            ph_cnt <= '0;
        end else begin
            sel_q  <= sel;
            ph_cnt <= (sel != sel_q) ? '0 : ph_cnt + 1'b1;
        end
    end

    // Remember the last carry levels for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_prev <= 1'b0;
            ten_prev <= 1'b0;
        end else begin
            min_prev <= min_carry;
            ten_prev <= ten_carry;
        end
    end

    // One tap per code: square-wave codes take a phase bit, the rest are 0
    for (genvar k = 0; k < NCODE; k++) begin : g_tap
        if (k < NUM_SQ) begin : g_sq
            assign sq[k] = ph_cnt[DIV_W-1-k];
        end else begin : g_none
            assign sq[k] = 1'b0;
        end
    end

    // Choose the next pin level from the registered select code
    always_comb begin
        case (sel_q)
            SEL_MIN: tmr_d = min_carry & ~min_prev;
            SEL_TEN: tmr_d = ten_carry & ~ten_prev;
            SEL_HI:  tmr_d = 1'b1;
            SEL_LO:  tmr_d = 1'b0;
            default: tmr_d = sq[sel_q];
        endcase
    end

    // Register the pin so that no level lasts less than a cycle
    always_ff @(posedge clk) begin
        if (!rst_n) tmr <= 1'b0;
        else        tmr <= tmr_d;
    end

    // R3: constant codes drive the pin on the next cycle
    a_r3_hold_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_HI) |=> tmr);
    a_r3_hold_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_LO) |=> !tmr);

    // R2: a carry pulse on the pin is a single cycle wide
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tmr && ((sel_q == SEL_MIN) || (sel_q == SEL_TEN)) |=> !tmr);

    // R10: one cycle after a code change the new square starts low
    a_r10_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != sel_q) && (sel < SEL_MIN) |=> ##1 !tmr);
endmodule

// File: rtl/rtc_miss_flag.sv
// Module: sticky missed-tick flag. Busy sets it; the trailing edge of the
// status-read strobe clears it; a set in the same cycle wins. Assumes
// stat_rd is synchronous to clk.
module rtc_miss_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic stat_rd,
    output logic missed
);
    logic rd_prev;
    logic rd_fall;

    // Keep the last strobe level for trailing-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= stat_rd;
    end

    // The strobe ends when it was high and is now low
    always_comb begin
        rd_fall = rd_prev & ~stat_rd;
    end

    // Update the flag, with set taking priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       missed <= 1'b0;
        else if (busy)    missed <= 1'b1;
        else if (rd_fall) missed <= 1'b0;
    end

    // R6: busy always leaves the flag set
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> missed);
    // R6: a trailing edge outside busy clears the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fall && !busy |=> !missed);
    // R6: without busy or a trailing edge the flag holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !rd_fall |=> $stable(missed));
    // R7: a collision of set and clear leaves the flag at 1
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rd_fall |=> missed);
endmodule

// File: rtl/rtc_tick_status.sv
// Module: top of the second-tick status and programmable output block.
// It joins the prescaler, the timer output selector and the missed-tick
// flag, and packs the status nibble. Assumes one clock (the timebase) and
// inputs synchronous to it.
module rtc_tick_status
    import rtc_tick_pkg::*;
#(
    parameter int DIV_W     = 15,
    parameter int KHZ_LOG2  = 3,
    parameter int BUSY_PRE  = 3,
    parameter int BUSY_POST = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] sel,
    input  logic       min_carry,
    input  logic       ten_carry,
    input  logic       stat_rd,
    output logic       tmr_out,
    output logic       khz_out,
    output logic [3:0] status
);
    logic busy;
    logic missed;

    rtc_prescaler #(
        .DIV_W(DIV_W), .KHZ_LOG2(KHZ_LOG2),
        .BUSY_PRE(BUSY_PRE), .BUSY_POST(BUSY_POST)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .busy(busy), .khz(khz_out)
    );

    rtc_tout_sel #(.DIV_W(DIV_W)) u_tout (
        .clk(clk), .rst_n(rst_n), .sel(sel_t'(sel)),
        .min_carry(min_carry), .ten_carry(ten_carry), .tmr(tmr_out)
    );

    rtc_miss_flag u_miss (
        .clk(clk), .rst_n(rst_n), .busy(busy), .stat_rd(stat_rd),
        .missed(missed)
    );

    // Pack the status nibble: busy above the missed-tick flag
    always_comb begin
        status = {2'b00, busy, missed};
    end

    // R5: the busy bit on the pins opens only after a quiet cycle
    a_r5_busy_opens: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(rst_n) && !$past(status[1]));
endmodule

// File: tb/tb_rtc_tick_status.sv
module tb_rtc_tick_status;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] sel;
    logic       min_carry, ten_carry, stat_rd;
    logic       tmr_out, khz_out;
    logic [3:0] status;

    int n_chk  = 0;
    int n_fail = 0;
    bit en     = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    rtc_tick_status dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .min_carry(min_carry),
        .ten_carry(ten_carry), .stat_rd(stat_rd), .tmr_out(tmr_out),
        .khz_out(khz_out), .status(status)
    );

    // Reference model state, updated behaviourally on each rising edge
    int m_cnt, m_sel, m_since, m_tmr, m_khz, m_missed, m_coll;
    int m_minp, m_tenp, m_rdp;

    function automatic int in_win(int c);
        return (c >= 32765 || c < 3) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 3; m_sel = 15; m_since = 0; m_tmr = 0; m_khz = 0;
            m_missed = 0; m_coll = 0; m_minp = 0; m_tenp = 0; m_rdp = 0;
        end else begin
            int b, f, nt;
            b = in_win(m_cnt);
            f = (m_rdp == 1 && stat_rd == 1'b0) ? 1 : 0;
            if (m_sel < 12)       nt = (m_since / (1 << (14 - m_sel))) % 2;
            else if (m_sel == 12) nt = (min_carry && !m_minp) ? 1 : 0;
            else if (m_sel == 13) nt = (ten_carry && !m_tenp) ? 1 : 0;
            else if (m_sel == 14) nt = 1;
            else                  nt = 0;
            m_coll = b & f;
            if (b) m_missed = 1;
            else if (f) m_missed = 0;
            m_khz = (m_cnt >> 2) & 1;
            m_cnt = (m_cnt + 1) % 32768;
            m_since = (int'(sel) != m_sel) ? 0 : (m_since + 1) % 32768;
            m_sel = int'(sel);
            m_minp = min_carry; m_tenp = ten_carry; m_rdp = stat_rd;
            m_tmr = nt;
        end
    end

    task automatic chk(input logic [3:0] act, input logic [3:0] exp,
                       input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model between edges
    always @(negedge clk) begin
        if (en) begin
            string tt;
            if (m_sel >= 14)      tt = "R3";
            else if (m_sel >= 12) tt = "R2";
            else if (m_since < 2 * (1 << (14 - m_sel))) tt = "R10";
            else                  tt = "R1";
            chk({3'b0, tmr_out}, 4'(m_tmr), tt, "tmr_out");
            chk({3'b0, khz_out}, 4'(m_khz), "R4", "khz_out");
            chk({3'b0, status[1]}, 4'(in_win(m_cnt)), "R5", "busy");
            chk({3'b0, status[0]}, 4'(m_missed),
                m_coll ? "R7" : "R6", "missed");
            chk(status, {2'b00, 1'(in_win(m_cnt)), 1'(m_missed)}, "R8",
                "status nibble");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_cnt(input int v);
        while (m_cnt != v) @(negedge clk);
    endtask

    task automatic rd_pulse();
        stat_rd = 1'b1; cyc(3); stat_rd = 1'b0; cyc(4);
    endtask

    initial begin
        rst_n = 1'b0; sel = 4'd0; min_carry = 1'b0; ten_carry = 1'b0;
        stat_rd = 1'b0;
        cyc(4);
        // R9: reset state at the pins
        chk({3'b0, tmr_out}, 4'd0, "R9", "tmr_out in reset");
        chk({3'b0, khz_out}, 4'd0, "R9", "khz_out in reset");
        chk(status, 4'd0, "R9", "status in reset");
        rst_n = 1'b1;
        cyc(1);
        en = 1;
        // R1: fastest, middle and slowest square waves
        sel = 4'd11; cyc(200);
        sel = 4'd5;  cyc(3000);
        sel = 4'd0;
        rd_pulse();                       // R6: clear with flag already 0
        // R7: trailing edge of the read lands on the first busy cycle
        wait_cnt(32764); stat_rd = 1'b1;
        cyc(1);           stat_rd = 1'b0;
        cyc(20);
        rd_pulse();                       // R6: clear outside busy
        cyc(100);
        // R10: select changes in mid half-period, faster then slower
        sel = 4'd3; cyc(37);
        sel = 4'd7; cyc(50);
        sel = 4'd3; cyc(4200);
        // R2: minute pulses, held carry, unselected carry
        sel = 4'd12; cyc(3);
        min_carry = 1'b1; cyc(1); min_carry = 1'b0; cyc(5);
        min_carry = 1'b1; cyc(5); min_carry = 1'b0; cyc(5);
        ten_carry = 1'b1; cyc(1); ten_carry = 1'b0; cyc(5);
        sel = 4'd13; cyc(3);
        ten_carry = 1'b1; cyc(1); ten_carry = 1'b0; cyc(5);
        min_carry = 1'b1; cyc(1); min_carry = 1'b0; cyc(5);
        // R3: constant levels
        sel = 4'd14; cyc(20);
        sel = 4'd15; cyc(20);
        // R1/R5/R6: one more full second at 1 Hz, with a late read
        sel = 4'd0; cyc(33000);
        rd_pulse();
        cyc(50);
        en = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_fail);
            $finish;
        end
    end
endmodule